// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps a 512-row asynchronous DRAM alive. After reset it waits out the power-up settling time. It then runs a burst of CAS-before-RAS refresh cycles and raises `initDone`. From then on it owes the memory one refresh per row interval, and it pays that debt by borrowing the memory bus from the access controller. The borrowing uses a level request (`refReq`) and a grant (`refGnt`). While the block owns the bus it drives the row strobe and both byte-lane column strobes. In a refresh cycle the address, write-enable and output-enable pins do not matter, so the block has none.

Refreshes that cannot be served at once, because the access controller keeps the bus, are counted in a small owed-refresh register. When that register is full, `refUrgent` tells the access controller to give the bus up. A level command, `selfRefReq`, puts the memory into self-refresh: the block enters through a CBR sequence and then holds both strobes low. When the command is withdrawn, and only once the minimum self-refresh time has passed, the block raises the row strobe and waits out the self-refresh precharge. The memory has refreshed itself during that time, so the owed count is cleared and the interval timer restarts. Every time is a cycle count derived from the `CLK_MHZ` parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and right after it is released, `rasN`, `ucasN` and `lcasN` are 1, and `refReq`, `busy`, `initDone`, `refUrgent` and `srActive` are 0.
- R2: For the first T_PWR = 200 x `CLK_MHZ` clocks after reset, `refReq` stays 0. It rises right after the T_PWR-th clock.
- R3: After the power-up wait, exactly `INIT_CYCLES` CBR cycles are issued before `initDone` rises. Once set, `initDone` stays 1 until reset.
- R4: A strobe is driven low only while `busy` and `refReq` are both 1. No strobe goes low while the grant is withheld.
- R5: `ucasN` and `lcasN` always carry the same value. In every cycle they fall at least T_CSR = ceil(5 ns x `CLK_MHZ`/1000) clocks before `rasN` falls, and they are still low when it falls.
- R6: In a refresh cycle `rasN` stays low for T_RAS clocks, where T_RAS is 40 ns in clocks and at least T_CHR+1. The column strobes stay low for exactly T_CHR = ceil(10 ns x `CLK_MHZ`/1000) of those clocks and are high again before `rasN` rises.
- R7: After `rasN` rises it stays high for at least T_RP clocks (the longer of 26 ns and 10 ns in clocks) before it falls again, and `refReq` stays 1 through that precharge.
- R8: After `initDone`, one refresh becomes owed every T_REFI = `WINDOW_US` x `CLK_MHZ` / `ROWS` clocks. With the grant always given, successive refresh cycles start exactly T_REFI clocks apart.
- R9: While the grant is withheld, owed refreshes accumulate up to `MAX_POSTPONE`, and further ones are dropped. `refUrgent` is 1 exactly when `MAX_POSTPONE` refreshes are owed. Once granted, all owed refreshes run back to back.
- R10: With `selfRefReq` at 1 after `initDone`, the block enters through a CBR sequence and then holds `rasN` and both column strobes low, with `srActive` at 1, for at least T_SR = 100 x `CLK_MHZ` + 1 clocks.
- R11: Self-refresh ends only when `selfRefReq` is 0 and T_SR has elapsed. `rasN` then stays high for T_RPS clocks (70 ns) while the bus is still held. The owed count is cleared, and the interval timer restarts from a full T_REFI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refGnt | input | 1 | Bus grant from the access controller |
| selfRefReq | input | 1 | Level command to be in self-refresh |
| refReq | output | 1 | Bus request, held for the whole refresh cycle |
| refUrgent | output | 1 | Owed-refresh count is at its limit |
| busy | output | 1 | Sequencer owns the bus and is running a cycle |
| initDone | output | 1 | Initialization refresh burst is complete |
| srActive | output | 1 | Memory is held in self-refresh |
| rasN | output | 1 | Row strobe, active low |
| ucasN | output | 1 | Upper byte-lane column strobe, active low |
| lcasN | output | 1 | Lower byte-lane column strobe, active low |

## Verification
The assertions check the strobe rules on every cycle. These are the byte-lane equality, CAS low at every RAS fall, the minimum RAS-high time, strobes only while the bus is held, silence during the power-up wait, an `initDone` that never drops, and `refUrgent` implying a request. Some behaviours only the bench scenarios can show, because they depend on counts over long spans. These are the exact size of the init burst, the T_REFI spacing, the saturation of the owed count while the grant is held back, the length of the self-refresh hold, and the cleared debt after exit.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_CASLO, ST_RASLO, ST_PRE, ST_SRHOLD, ST_SRPRE
  } seqState_t;

  // which duration the phase timer is loaded with
  typedef enum logic [2:0] {
    PH_CSR, PH_RAS, PH_RP, PH_SR, PH_RPS
  } phSel_t;

  typedef struct packed {
    logic   ldPh;     // load phase timer
    phSel_t phSel;    // value to load
    logic   cbrDone;  // one CBR refresh cycle has completed
    logic   srHold;   // in self-refresh: clear debt, hold interval timer
  } seqStrobe_t;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ns to clock cycles, rounded up, never below one
  function automatic int nsCyc(input int ns, input int mhz);
    return maxi(1, (ns * mhz + 999) / 1000);
  endfunction

endpackage

// File: rtl/refseq_dp.sv
module refseq_dp
  import refseq_pkg::*;
#(
  parameter int T_PWR        = 20000,
  parameter int T_REFI       = 1562,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 4,
  parameter int T_CHR        = 1,
  parameter int T_RP         = 3,
  parameter int T_SR         = 10001,
  parameter int T_RPS        = 7,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_POSTPONE = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  output logic       phDone,
  output logic       casHold,
  output logic       initDone,
  output logic       pendNz,
  output logic       pendFull
);

  localparam int PH_MAX = maxi(maxi(T_PWR, T_SR), maxi(maxi(T_RAS, T_RP), maxi(T_CSR, T_RPS)));
  localparam int PW     = $clog2(PH_MAX + 1);
  localparam int RW     = $clog2(T_REFI + 1);
  localparam int IW     = $clog2(INIT_CYCLES + 1);
  localparam int QW     = $clog2(MAX_POSTPONE + 1);

  logic [PW-1:0] phCnt, phLoad;
  logic [RW-1:0] refiCnt;
  logic [IW-1:0] initCnt;
  logic [QW-1:0] pendCnt;
  logic          tick, incPend, decPend;

  always_comb begin
    unique case (stb.phSel)
      PH_CSR:  phLoad = PW'(T_CSR - 1);
      PH_RAS:  phLoad = PW'(T_RAS - 1);
      PH_RP:   phLoad = PW'(T_RP - 1);
      PH_SR:   phLoad = PW'(T_SR - 1);
      default: phLoad = PW'(T_RPS - 1);
    endcase
  end

  // phase timer: counts the current strobe phase down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phCnt <= PW'(T_PWR - 1);
    else if (stb.ldPh)      phCnt <= phLoad;
    else if (phCnt != '0)   phCnt <= phCnt - 1'b1;
  end

  assign phDone  = (phCnt == '0);
  assign casHold = (phCnt >= PW'(T_RAS - T_CHR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          initCnt <= '0;
    else if (stb.cbrDone && !initDone)  initCnt <= initCnt + 1'b1;
  end

  assign initDone = (initCnt == IW'(INIT_CYCLES));

  // interval timer: free-running after init, held during self-refresh
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          refiCnt <= RW'(T_REFI - 1);
    else if (!initDone || stb.srHold || refiCnt == '0)  refiCnt <= RW'(T_REFI - 1);
    else                                                refiCnt <= refiCnt - 1'b1;
  end

  assign tick    = initDone && !stb.srHold && (refiCnt == '0);
  assign decPend = stb.cbrDone && initDone && pendNz;
  assign incPend = tick && (!pendFull || decPend);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      pendCnt <= '0;
    else if (stb.srHold)            pendCnt <= '0;
    else if (incPend && !decPend)   pendCnt <= pendCnt + 1'b1;
    else if (decPend && !incPend)   pendCnt <= pendCnt - 1'b1;
  end

  assign pendNz   = (pendCnt != '0);
  assign pendFull = (pendCnt == QW'(MAX_POSTPONE));

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGnt,
  input  logic       selfRefReq,
  input  logic       phDone,
  input  logic       casHold,
  input  logic       initDone,
  input  logic       pendNz,
  output seqStrobe_t stb,
  output logic       refReq,
  output logic       busy,
  output logic       srActive,
  output logic       rasN,
  output logic       casN
);

  seqState_t state, stateNxt;
  logic      srMode, srModeNxt;
  logic      srWant, want;

  assign srWant = selfRefReq && initDone;
  assign want   = !initDone || pendNz || srWant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PWR;
      srMode <= 1'b0;
    end else begin
      state  <= stateNxt;
      srMode <= srModeNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    srModeNxt = srMode;
    stb       = '{ldPh: 1'b0, phSel: PH_CSR, cbrDone: 1'b0, srHold: 1'b0};
    unique case (state)
      ST_PWR:   if (phDone) stateNxt = ST_IDLE;
      ST_IDLE:  if (want && refGnt) begin
                  stb.ldPh  = 1'b1;
                  stb.phSel = PH_CSR;
                  srModeNxt = srWant;
                  stateNxt  = ST_CASLO;
                end
      ST_CASLO: if (phDone) begin
                  stb.ldPh  = 1'b1;
                  stb.phSel = srMode ? PH_SR : PH_RAS;
                  stateNxt  = srMode ? ST_SRHOLD : ST_RASLO;
                end
      ST_RASLO: if (phDone) begin
                  stb.ldPh    = 1'b1;
                  stb.phSel   = PH_RP;
                  stb.cbrDone = 1'b1;
                  stateNxt    = ST_PRE;
                end
      ST_PRE:   if (phDone) stateNxt = ST_IDLE;
      ST_SRHOLD: begin
                  stb.srHold = 1'b1;
                  if (phDone && !selfRefReq) begin
                    stb.ldPh  = 1'b1;
                    stb.phSel = PH_RPS;
                    stateNxt  = ST_SRPRE;
                  end
                end
      ST_SRPRE: begin
                  stb.srHold = 1'b1;
                  if (phDone) stateNxt = ST_IDLE;
                end
      default:  stateNxt = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_PWR) && (state != ST_IDLE);
  assign refReq   = busy || ((state == ST_IDLE) && want);
  assign srActive = (state == ST_SRHOLD);
  assign rasN     = !((state == ST_RASLO) || (state == ST_SRHOLD));
  assign casN     = !((state == ST_CASLO) || (state == ST_SRHOLD) ||
                      ((state == ST_RASLO) && casHold));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import refseq_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int ROWS         = 512,
  parameter int WINDOW_US    = 8000,
  parameter int PWR_US       = 200,
  parameter int SR_US        = 100,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_POSTPONE = 8,
  parameter int NS_CSR       = 5,
  parameter int NS_CHR       = 10,
  parameter int NS_RAS       = 40,
  parameter int NS_RP        = 26,
  parameter int NS_RPC       = 10,
  parameter int NS_RPS       = 70
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGnt,
  input  logic selfRefReq,
  output logic refReq,
  output logic refUrgent,
  output logic busy,
  output logic initDone,
  output logic srActive,
  output logic rasN,
  output logic ucasN,
  output logic lcasN
);

  localparam int T_PWR  = maxi(1, PWR_US * CLK_MHZ);
  localparam int T_REFI = maxi(2, (WINDOW_US * CLK_MHZ) / ROWS);
  localparam int T_CSR  = nsCyc(NS_CSR, CLK_MHZ);
  localparam int T_CHR  = nsCyc(NS_CHR, CLK_MHZ);
  localparam int T_RAS  = maxi(nsCyc(NS_RAS, CLK_MHZ), T_CHR + 1);
  localparam int T_RP   = maxi(nsCyc(NS_RP, CLK_MHZ), nsCyc(NS_RPC, CLK_MHZ));
  localparam int T_SR   = SR_US * CLK_MHZ + 1;
  localparam int T_RPS  = nsCyc(NS_RPS, CLK_MHZ);

  seqStrobe_t stb;
  logic phDone, casHold, pendNz, pendFull, casN;

  refseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .selfRefReq(selfRefReq),
    .phDone(phDone), .casHold(casHold), .initDone(initDone), .pendNz(pendNz),
    .stb(stb), .refReq(refReq), .busy(busy), .srActive(srActive),
    .rasN(rasN), .casN(casN)
  );

  refseq_dp #(
    .T_PWR(T_PWR), .T_REFI(T_REFI), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .T_CHR(T_CHR), .T_RP(T_RP), .T_SR(T_SR), .T_RPS(T_RPS),
    .INIT_CYCLES(INIT_CYCLES), .MAX_POSTPONE(MAX_POSTPONE)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .phDone(phDone), .casHold(casHold),
    .initDone(initDone), .pendNz(pendNz), .pendFull(pendFull)
  );

  assign refUrgent = pendFull;
  assign ucasN     = casN;
  assign lcasN     = casN;

endmodule

// File: rtl/refseq_chk.sv
module refseq_chk #(
  parameter int T_PWR = 20000,
  parameter int T_RP  = 3
) (
  input logic clk,
  input logic rstN,
  input logic refReq,
  input logic refUrgent,
  input logic busy,
  input logic initDone,
  input logic srActive,
  input logic rasN,
  input logic ucasN,
  input logic lcasN
);

  localparam int SW = $clog2(T_PWR + 1);
  localparam int HW = $clog2(T_RP + 1);

  logic [SW-1:0] sinceRst;
  logic [HW-1:0] rasHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sinceRst <= '0;
    else if (sinceRst < SW'(T_PWR))     sinceRst <= sinceRst + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rasHigh <= HW'(T_RP);
    else if (!rasN)                     rasHigh <= '0;
    else if (rasHigh < HW'(T_RP))       rasHigh <= rasHigh + 1'b1;
  end

  a_r2_quiet_powerup: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SW'(T_PWR)) |-> !refReq);

  a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r4_strobe_owned: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !ucasN || !lcasN) |-> (busy && refReq));

  a_r5_lanes_equal: assert property (@(posedge clk) disable iff (!rstN)
    ucasN == lcasN);

  a_r5_cas_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!ucasN && $past(!ucasN)));

  a_r6_cas_up_first: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasN) && !$past(srActive)) |-> $past(ucasN));

  a_r7_ras_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(rasHigh) >= HW'(T_RP)));

  a_r9_urgent_requests: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

  a_r10_sr_strobes_low: assert property (@(posedge clk) disable iff (!rstN)
    srActive |-> (!rasN && !ucasN && !lcasN));

endmodule

bind dram_refresh_seq refseq_chk #(.T_PWR(T_PWR), .T_RP(T_RP)) uChk (
  .clk(clk), .rstN(rstN), .refReq(refReq), .refUrgent(refUrgent), .busy(busy),
  .initDone(initDone), .srActive(srActive), .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ    = 4;
  localparam int MAXP   = 4;
  localparam int E_PWR  = 200 * MHZ;
  localparam int E_REFI = 8000 * MHZ / 512;
  localparam int E_CSR  = 1;
  localparam int E_CHR  = 1;
  localparam int E_RAS  = 2;
  localparam int E_RP   = 1;
  localparam int E_SR   = 100 * MHZ + 1;

  logic clk = 1'b0, rstN = 1'b0, refGnt = 1'b0, selfRefReq = 1'b0;
  logic refReq, refUrgent, busy, initDone, srActive, rasN, ucasN, lcasN;

  dram_refresh_seq #(.CLK_MHZ(MHZ), .MAX_POSTPONE(MAXP)) u0 (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .selfRefReq(selfRefReq),
    .refReq(refReq), .refUrgent(refUrgent), .busy(busy), .initDone(initDone),
    .srActive(srActive), .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int cbrCount = 0, lastFall = 0, lastRise = 0, laneBad = 0, unexpected = 0;
  int expQ[$];     // 0 = refresh cycle, 1 = self-refresh
  bit gntEn = 1'b1, finished = 1'b0;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expectEv(input int kind, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(kind);
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // grant follows the request while enabled
  initial forever begin
    @(negedge clk);
    refGnt = refReq && gntEn;
  end

  // monitor: measure each strobe cycle and compare with the queued expectation
  initial begin
    int lead = 0, lowLen = 0, casLow = 0, kind = 0;
    bit prevRas = 1'b1;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (ucasN !== lcasN) laneBad++;
      if (prevRas && !rasN) begin
        if (expQ.size() == 0) begin unexpected++; kind = 0; end
        else kind = expQ.pop_front();
        chk(lead >= E_CSR && !ucasN, "R5 cas lead", lead, E_CSR);
        if (cbrCount > 0) chk(cyc - lastRise >= E_RP, "R7 ras high", cyc - lastRise, E_RP);
        cbrCount++;
        lastFall = cyc;
        lowLen = 1; casLow = ucasN ? 0 : 1;
      end else if (!rasN) begin
        lowLen++;
        if (!ucasN) casLow++;
      end else if (!prevRas && rasN) begin
        lastRise = cyc;
        if (kind == 0) begin
          chk(lowLen == E_RAS, "R6 ras low", lowLen, E_RAS);
          chk(casLow == E_CHR, "R6 cas hold", casLow, E_CHR);
        end else begin
          chk(lowLen >= E_SR, "R10 sr hold", lowLen, E_SR);
        end
      end
      lead = (!ucasN && rasN) ? lead + 1 : 0;
      prevRas = rasN;
    end
  end

  task automatic finish();
    if (finished) return;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish();
  end

  initial begin
    int t10, sf;
    repeat (4) @(negedge clk);
    chk(rasN && ucasN && lcasN && !refReq && !busy && !initDone && !refUrgent && !srActive,
        "R1 reset outputs", {rasN, ucasN, lcasN, refReq, busy, initDone}, 6'b111000);
    rstN = 1'b1;
    chk(rasN && ucasN && !refReq && !initDone, "R1 after release", {rasN, ucasN, refReq}, 3'b110);

    // R2: power-up wait
    expectEv(0, 8);
    waitCyc(E_PWR - 10);
    chk(!refReq, "R2 quiet", refReq, 0);
    while (!refReq) @(negedge clk);
    chk(cyc == E_PWR, "R2 first request", cyc, E_PWR);

    // R3: init burst
    while (!initDone) @(negedge clk);
    chk(cbrCount == 8, "R3 init count", cbrCount, 8);
    chk(expQ.size() == 0, "R3 queue drained", expQ.size(), 0);

    // R8: steady-state interval
    expectEv(0, 2);
    while (cbrCount < 9) @(negedge clk);
    t10 = lastFall;
    while (cbrCount < 10) @(negedge clk);
    chk(lastFall - t10 == E_REFI, "R8 interval", lastFall - t10, E_REFI);
    chk(initDone, "R3 sticky", initDone, 1);
    t10 = lastFall;

    // R9: postponement with grant withheld
    waitCyc(t10 + 5);
    gntEn = 1'b0;
    waitCyc(t10 + 200);
    chk(!refUrgent, "R9 not yet urgent", refUrgent, 0);
    chk(refReq, "R9 request pending", refReq, 1);
    chk(rasN && ucasN && cbrCount == 10, "R4 no strobe ungranted", cbrCount, 10);
    waitCyc(t10 + 260);
    chk(refUrgent, "R9 urgent", refUrgent, 1);
    waitCyc(t10 + 320);
    expectEv(0, MAXP);
    gntEn = 1'b1;
    waitCyc(t10 + 350);
    chk(cbrCount == 10 + MAXP, "R9 burst saturated", cbrCount - 10, MAXP);
    chk(!refUrgent, "R9 urgent cleared", refUrgent, 0);

    // R10/R11: self-refresh
    expectEv(1, 1);
    selfRefReq = 1'b1;
    while (cbrCount < 11 + MAXP) @(negedge clk);
    sf = lastFall;
    waitCyc(sf + 50);
    chk(srActive && !rasN && !ucasN && !lcasN, "R10 sr held", srActive, 1);
    waitCyc(sf + 100);
    selfRefReq = 1'b0;
    waitCyc(sf + 300);
    chk(!rasN && srActive, "R11 min hold", rasN, 0);
    expectEv(0, 1);
    while (cbrCount < 12 + MAXP) @(negedge clk);
    chk(lastFall - lastRise >= E_REFI && lastFall - lastRise <= E_REFI + 4,
        "R11 debt cleared", lastFall - lastRise, E_REFI + 3);

    waitCyc(cyc + 5);
    chk(laneBad == 0, "R5 lanes equal", laneBad, 0);
    chk(unexpected == 0 && expQ.size() == 0, "R4 unexpected strobe", unexpected, 0);
    finish();
  end

endmodule